// File: doc/BRIEF.md
# Cascaded Depth-Expansion Bit RAM

This block is a one-bit-wide synchronous RAM whose depth is twice that of a single storage half. Two identical halves share the low address bits. The top address bit decides which half takes a write and which half's read bit reaches the output. The halves are not joined by a general multiplexer. Each half carries a cascade input and a cascade output. The lower half's cascade input is tied to zero, and its cascade output feeds the upper half's cascade input. Each half forwards either its own registered read bit or whatever arrives on its cascade input. The upper half's unconnected cascade output is the read result.

With `HALF_AW = 15` each half holds 32,768 bits and the pair acts as a 65,536 x 1 memory. The default parameter keeps the arrays small for elaboration. Writes are read-first. Contents start at zero. A parameter adds an output register that costs one extra cycle of latency. Depth expansion is only legal at a data width of one bit, and any other `DATA_W` stops the run at time zero.

Every port is plain: the memory accepts an access on every clock and has no back-pressure. With a fixed latency the caller knows exactly when each result appears, so no valid/ready handshake is used.

Top module: `bitram_cascade`

## Requirements
- R1: With `OUT_REG = 0`, `dout` after a rising edge holds the stored bit at the address presented at that edge, so the read latency is one cycle.
- R2: Address bit `HALF_AW` (the top bit) selects the half. Two addresses that differ only in that bit are independent locations. While the upper half is selected, the lower half's cascade output is 0.
- R3: While `we` is 0, a cycle leaves the memory unchanged, whatever `din` holds.
- R4: A read of the address being written in the same cycle returns the contents from before the write (read-first).
- R5: Every location reads 0 before it is first written.
- R6: With `OUT_REG = 1`, `dout` is the `OUT_REG = 0` result delayed by exactly one more cycle.
- R7: A synchronous reset (`rst` = 1) drives `dout` to 0 on the next edge in both configurations and does not alter stored contents.
- R8: The first and last entries of each half (addresses 0, 2^HALF_AW - 1, 2^HALF_AW and 2^(HALF_AW+1) - 1) each store and return their own bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset of the read and output registers, active high |
| addr | input | HALF_AW+1 | Word address; the top bit selects the half |
| we | input | 1 | Write enable for the location at `addr` |
| din | input | DATA_W | Write data bit |
| dout | output | DATA_W | Read data |

## Verification
On every cycle, the assertions check the cascade routing of R2: the lower stage must forward zero while the upper half is addressed, and must reach the output when it is addressed itself. They also check write-then-read and repeated-read stability for R1, the extra pipeline stage for R6, and the output clearing on reset for R7. Some properties depend on the history of a location across many cycles: zero initial contents, read-first collisions, ignored write data, the independence of the two halves at the same low address, and contents kept through a reset. Only the bench's scenarios show these, by comparing both configurations against its own model of the memory.

// File: rtl/bitram_pkg.sv
package bitram_pkg;

  // Role of a storage half inside the cascade chain; the value equals the
  // top address bit that makes that half the active one.
  typedef enum logic {
    HALF_LOWER = 1'b0,
    HALF_UPPER = 1'b1
  } half_role_e;

  localparam int unsigned NUM_HALVES = 2;

endpackage

// File: rtl/bitram_half.sv
module bitram_half
  import bitram_pkg::*;
#(
  parameter int unsigned HALF_AW = 10,
  parameter int unsigned DATA_W  = 1,
  parameter half_role_e  ROLE    = HALF_LOWER
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [HALF_AW-1:0] addr_lo,
  input  logic               bank_sel,
  input  logic [DATA_W-1:0]  din,
  input  logic [DATA_W-1:0]  cas_in,
  output logic [DATA_W-1:0]  cas_out
);

  localparam int unsigned ENTRIES = 1 << HALF_AW;

  logic [DATA_W-1:0] store [ENTRIES] = '{default: '0};
  logic [DATA_W-1:0] rd_q;
  logic              own_q;
  logic              is_mine;

  assign is_mine = (half_role_e'(bank_sel) == ROLE);

  // Storage write: only the half matched by the top address bit.
  always_ff @(posedge clk) begin
    if (we && is_mine) begin
      store[addr_lo] <= din;
    end
  end

  // Read-first register plus the delayed selection flag that lines up
  // with the read data it qualifies.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      own_q <= 1'b0;
    end else begin
      rd_q  <= store[addr_lo];
      own_q <= is_mine;
    end
  end

  // Cascade stage: forward own bit when this half was addressed,
  // otherwise pass along what the previous stage delivered.
  assign cas_out = own_q ? rd_q : cas_in;

endmodule

// File: rtl/bitram_cascade.sv
module bitram_cascade
  import bitram_pkg::*;
#(
  parameter int unsigned HALF_AW = 10,
  parameter int unsigned DATA_W  = 1,
  parameter bit          OUT_REG = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [HALF_AW:0]    addr,
  input  logic                we,
  input  logic [DATA_W-1:0]   din,
  output logic [DATA_W-1:0]   dout
);

  localparam int unsigned ADDR_W = HALF_AW + 1;

  logic [DATA_W-1:0] chain [NUM_HALVES+1];
  logic [DATA_W-1:0] mux_bit;

  // Depth expansion is defined only for single-bit words.
  generate
    if (DATA_W != 1) begin : g_width_reject
      initial $fatal(1, "bitram_cascade: depth cascade needs DATA_W == 1");
    end
  endgenerate

  // Head of the chain is a constant; the tail is the read result.
  assign chain[0] = '0;

  generate
    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
      localparam half_role_e ROLE_G = (g == 0) ? HALF_LOWER : HALF_UPPER;
      bitram_half #(
        .HALF_AW (HALF_AW),
        .DATA_W  (DATA_W),
        .ROLE    (ROLE_G)
      ) u_half (
        .clk      (clk),
        .rst      (rst),
        .we       (we),
        .addr_lo  (addr[HALF_AW-1:0]),
        .bank_sel (addr[ADDR_W-1]),
        .din      (din),
        .cas_in   (chain[g]),
        .cas_out  (chain[g+1])
      );
    end
  endgenerate

  assign mux_bit = chain[NUM_HALVES];

  generate
    if (OUT_REG) begin : g_out_reg
      logic [DATA_W-1:0] out_q;
      always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= mux_bit;
      end
      assign dout = out_q;
    end else begin : g_out_comb
      assign dout = mux_bit;
    end
  endgenerate

endmodule

// File: rtl/bitram_cascade_chk.sv
module bitram_cascade_chk #(
  parameter int unsigned HALF_AW = 10,
  parameter int unsigned DATA_W  = 1,
  parameter bit          OUT_REG = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic [HALF_AW:0]  addr,
  input logic              we,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout,
  input logic [DATA_W-1:0] lo_bit,
  input logic [DATA_W-1:0] mux_bit
);

  logic rst_d = 1'b0;
  logic seen_edge = 1'b0;
  always_ff @(posedge clk) begin
    rst_d     <= rst;
    seen_edge <= 1'b1;
  end

  // R7: an edge with reset asserted leaves the output at zero.
  always @(negedge clk) begin
    if (seen_edge && rst_d) begin
      p_rst_clear_r7: assert (dout == '0)
        else $error("reset did not clear dout");
    end
  end

  // R2: upper half addressed -> lower stage forwards the zero head.
  p_upper_steer_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(addr[HALF_AW])) |-> (lo_bit == '0));

  generate
    if (!OUT_REG) begin : g_comb_props
      // R2: lower half addressed -> its stage reaches the output.
      p_lower_route_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(addr[HALF_AW])) |-> (dout == lo_bit));

      // R1: a write followed by a read of the same address returns it.
      p_wr_rd_r1: assert property (@(posedge clk) disable iff (rst)
        (we ##1 (!we && !rst && addr == $past(addr))) |=> (dout == $past(din, 2)));

      // R1: repeated reads of one address with no writes stay stable.
      p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !we && !$past(we) && addr == $past(addr)) |=> $stable(dout));
    end else begin : g_reg_props
      // R6: the output stage delays the selected bit by one cycle.
      p_pipe_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (dout == $past(mux_bit)));
    end
  endgenerate

endmodule

bind bitram_cascade bitram_cascade_chk #(
  .HALF_AW (HALF_AW),
  .DATA_W  (DATA_W),
  .OUT_REG (OUT_REG)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (addr),
  .we      (we),
  .din     (din),
  .dout    (dout),
  .lo_bit  (chain[1]),
  .mux_bit (mux_bit)
);

// File: tb/bitram_cascade_test.sv
module bitram_cascade_test;

  localparam int unsigned HALF_AW = 10;
  localparam int unsigned ADDR_W  = HALF_AW + 1;
  localparam int unsigned DEPTH   = 1 << ADDR_W;
  localparam int unsigned HALF    = 1 << HALF_AW;

  typedef struct {
    logic  exp;
    logic  is_rst;
    string tag;
  } sb_item_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              we = 1'b0;
  logic [0:0]        din = '0;
  logic [0:0]        dout_c;
  logic [0:0]        dout_p;

  bit       ref_mem [DEPTH];
  sb_item_t sb [$];
  int       n_chk = 0;
  int       n_fail = 0;
  logic     last_exp = 1'b0;

  always #4 clk = ~clk;

  bitram_cascade #(.HALF_AW(HALF_AW), .DATA_W(1), .OUT_REG(1'b0)) uut (
    .clk(clk), .rst(rst), .addr(addr), .we(we), .din(din), .dout(dout_c));

  bitram_cascade #(.HALF_AW(HALF_AW), .DATA_W(1), .OUT_REG(1'b1)) uut_p (
    .clk(clk), .rst(rst), .addr(addr), .we(we), .din(din), .dout(dout_p));

  task automatic check(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, got, exp, $time);
    end
  endtask

  // Driver: applies one access and queues the bench's own expectation.
  task automatic op(input logic [ADDR_W-1:0] a, input logic w, input logic d,
                    input string tag);
    sb_item_t it;
    @(negedge clk);
    rst = 1'b0; addr = a; we = w; din = d;
    it.exp = ref_mem[a];          // read-first: value before this write
    it.is_rst = 1'b0;
    it.tag = tag;
    if (w) ref_mem[a] = d;
    sb.push_back(it);
  endtask

  task automatic rst_op(input string tag);
    sb_item_t it;
    @(negedge clk);
    rst = 1'b1; we = 1'b0;
    it.exp = 1'b0; it.is_rst = 1'b1; it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: after each edge, compare both configurations.
  always @(posedge clk) begin
    sb_item_t it;
    logic     exp_p;
    #2;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      check(it.tag, dout_c[0], it.exp);
      exp_p = it.is_rst ? 1'b0 : last_exp;
      check(it.is_rst ? "R7 registered" : "R6 registered", dout_p[0], exp_p);
      last_exp = it.is_rst ? 1'b0 : it.exp;
    end
  end

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 1'b0;
    repeat (3) rst_op("R7 reset");

    // R5: untouched locations in both halves read zero.
    op(ADDR_W'(0), 1'b0, 1'b1, "R5");
    op(ADDR_W'(HALF - 1), 1'b0, 1'b0, "R5");
    op(ADDR_W'(HALF), 1'b0, 1'b0, "R5");
    op(ADDR_W'(DEPTH - 1), 1'b0, 1'b0, "R5");
    op(ADDR_W'(500), 1'b0, 1'b0, "R5");

    // R1 / R2: lower write, then the same low bits in the upper half.
    op(ADDR_W'(5), 1'b1, 1'b1, "R1");
    op(ADDR_W'(5), 1'b0, 1'b0, "R1");
    op(ADDR_W'(5 + HALF), 1'b0, 1'b0, "R2");
    op(ADDR_W'(9 + HALF), 1'b1, 1'b1, "R2");
    op(ADDR_W'(9), 1'b0, 1'b0, "R2");
    op(ADDR_W'(9 + HALF), 1'b0, 1'b0, "R2");

    // R3: data without enable is ignored.
    op(ADDR_W'(77), 1'b0, 1'b1, "R3");
    op(ADDR_W'(77), 1'b0, 1'b1, "R3");
    op(ADDR_W'(77 + HALF), 1'b0, 1'b1, "R3");

    // R4: collision returns the old contents.
    op(ADDR_W'(200), 1'b1, 1'b1, "R4");
    op(ADDR_W'(200), 1'b1, 1'b0, "R4");
    op(ADDR_W'(200), 1'b0, 1'b0, "R4");

    // R8: first and last entry of each half.
    op(ADDR_W'(HALF - 1), 1'b1, 1'b1, "R8");
    op(ADDR_W'(HALF), 1'b1, 1'b0, "R8");
    op(ADDR_W'(DEPTH - 1), 1'b1, 1'b1, "R8");
    op(ADDR_W'(0), 1'b1, 1'b1, "R8");
    op(ADDR_W'(HALF - 1), 1'b0, 1'b0, "R8");
    op(ADDR_W'(HALF), 1'b0, 1'b0, "R8");
    op(ADDR_W'(DEPTH - 1), 1'b0, 1'b0, "R8");
    op(ADDR_W'(0), 1'b0, 1'b0, "R8");

    // R7: reset mid-run keeps contents.
    rst_op("R7 reset");
    rst_op("R7 reset");
    op(ADDR_W'(DEPTH - 1), 1'b0, 1'b0, "R7 retained");
    op(ADDR_W'(9 + HALF), 1'b0, 1'b0, "R7 retained");

    // R1: mixed traffic on a small address set spanning both halves.
    for (int k = 0; k < 400; k++) begin
      logic [ADDR_W-1:0] a;
      a = '0;
      a[3:0] = 4'($urandom);
      a[ADDR_W-1] = 1'($urandom);
      op(a, 1'($urandom), 1'($urandom), "R1 mixed");
    end

    @(negedge clk);
    we = 1'b0;
    repeat (4) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule